// File: doc/BRIEF.md
# Calibration Fuse Programmer

This block keeps a small write-once calibration store: a 5-bit voltage offset, a 3-bit temperature coefficient and a seal flag. Host traffic arrives as byte writes with a data/command select. Commands switch a power-down state and a calibration mode. While calibration mode is active, data writes push one bit each into a 9-bit serial chain. A programming strobe then burns every chain position that holds a 1 into the matching fuse cell.

Fuse cells only ever go from 0 to 1. The block flags two kinds of misuse: a strobe that would burn more than one cell, and a strobe that targets a cell that is already burned. Once the seal fuse is burned and calibration mode has been left, the mode can never be entered again. The stored fields drive the outputs directly, so downstream logic sees each burned bit on the cycle after the strobe.

Top module: `otp_cal_prog`

## Requirements
- R1: At power-up all fuse cells read 0. After reset, calibration mode is inactive and both error flags are 0.
- R2: A command write (wr_en=1, dc=0) of 8'h20 enters power-down and 8'h21 leaves it. 8'h30 enters calibration mode, but only while in power-down; otherwise it is ignored. 8'h31 leaves calibration mode.
- R3: In calibration mode each data write (wr_en=1, dc=1) shifts db[0] into the chain. Over nine writes the bits are taken in this order: offset bit 4 down to bit 0, then coefficient bit 2 down to bit 0, then seal. Further writes push the oldest bit out.
- R4: A strobe in calibration mode while exactly one chain bit is 1 sets the matching fuse cell. The matching output bit is 1 from the cycle after the strobe.
- R5: A fuse cell that is 1 never returns to 0, even across reset.
- R6: A strobe whose single 1 targets a cell that is already 1 raises err_reprog for one cycle and leaves the fuses unchanged.
- R7: A strobe while more than one chain bit is 1 raises err_multi for one cycle and programs no cell.
- R8: Outside calibration mode, the strobe changes no fuse and data writes do not enter the chain.
- R9: While calibration mode stays active after the seal cell is burned, further cells can still be programmed. Once the mode is left with the seal burned, 8'h30 is ignored even in power-down.
- R10: Reset leaves calibration mode and power-down and clears the chain. It keeps every fuse cell.
- R11: Cells may be programmed in any order; each strobe adds its bit to those already burned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| dc | input | 1 | 1 = data write, 0 = command write |
| db | input | 8 | Write byte |
| prog_strobe | input | 1 | Programming strobe |
| ofs_o | output | 5 | Stored voltage-offset field |
| tc_o | output | 3 | Stored temperature-coefficient field |
| sealed_o | output | 1 | Seal fuse state |
| cal_active_o | output | 1 | Calibration mode active |
| err_multi_o | output | 1 | One-cycle flag: strobe with several chain ones |
| err_reprog_o | output | 1 | One-cycle flag: strobe on an already burned cell |

## Verification
Every cycle, the assertions check four things. Fuses never fall. A rejected or out-of-mode strobe leaves the fuses untouched. The chain holds still when no shift is requested. Calibration entry is refused without power-down or after sealing. Only the bench scenarios can show the rest: the bit order of the chain, the loss of the oldest bit on overflow, free programming order, and that reset keeps the fuses but empties the chain. They also show that a sealed part can still be programmed before the mode is left.

// File: rtl/otp_cal_pkg.sv
package otp_cal_pkg;
  localparam int OFS_W  = 5;
  localparam int TC_W   = 3;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] CMD_PD_ON     = 8'h20;
  localparam logic [BYTE_W-1:0] CMD_PD_OFF    = 8'h21;
  localparam logic [BYTE_W-1:0] CMD_CAL_ENTER = 8'h30;
  localparam logic [BYTE_W-1:0] CMD_CAL_EXIT  = 8'h31;
endpackage

// File: rtl/otp_mode_ctrl.sv
module otp_mode_ctrl
  import otp_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic [BYTE_W-1:0] cmd,
  input  logic              sealed_i,
  output logic              cal_o
);
  logic pd_q, cal_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pd_q  <= 1'b0;
      cal_q <= 1'b0;
    end else if (cmd_wr) begin
      case (cmd)
        CMD_PD_ON:     pd_q  <= 1'b1;
        CMD_PD_OFF:    pd_q  <= 1'b0;
        CMD_CAL_ENTER: if (pd_q && !sealed_i) cal_q <= 1'b1;
        CMD_CAL_EXIT:  cal_q <= 1'b0;
        default: ;
      endcase
    end
  end

  assign cal_o = cal_q;

  // R2: no entry without power-down
  a_r2_enter_needs_pd: assert property (@(posedge clk) disable iff (rst)
    (!cal_q && !pd_q) |=> !cal_q);
  // R9: sealed part stays out once outside
  a_r9_seal_lockout: assert property (@(posedge clk) disable iff (rst)
    (!cal_q && sealed_i) |=> !cal_q);
endmodule

// File: rtl/otp_shift_chain.sv
module otp_shift_chain #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         bit_i,
  output logic [W-1:0] chain_o
);
  logic [W-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst)           chain_q <= '0;
    else if (shift_en) chain_q <= {chain_q[W-2:0], bit_i};
  end

  assign chain_o = chain_q;

  // R8: chain frozen without a shift request
  a_r8_chain_hold: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(chain_q));
endmodule

// File: rtl/otp_cell_bank.sv
module otp_cell_bank #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cal_i,
  input  logic         strobe_i,
  input  logic [W-1:0] pattern_i,
  output logic [W-1:0] cells_o,
  output logic         err_multi_o,
  output logic         err_reprog_o
);
  logic [W-1:0] cells_q = '0;
  logic         fire, several, clash;

  assign fire    = strobe_i && cal_i;
  assign several = $countones(pattern_i) > 1;
  assign clash   = |(pattern_i & cells_q);

  // fuses are non-volatile: no reset term
  always_ff @(posedge clk) begin
    if (fire && !several) cells_q <= cells_q | pattern_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_multi_o  <= 1'b0;
      err_reprog_o <= 1'b0;
    end else begin
      err_multi_o  <= fire && several;
      err_reprog_o <= fire && !several && clash;
    end
  end

  assign cells_o = cells_q;

  // R5: burned cells never clear
  a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((cells_q & $past(cells_q)) == $past(cells_q)));
  // R7: multi-bit strobe flagged and blocked
  a_r7_multi_block: assert property (@(posedge clk) disable iff (rst)
    (strobe_i && cal_i && $countones(pattern_i) > 1) |=> (err_multi_o && $stable(cells_q)));
  // R6: re-burn flagged, fuses unchanged
  a_r6_reprog_flag: assert property (@(posedge clk) disable iff (rst)
    (strobe_i && cal_i && $countones(pattern_i) == 1 && |(pattern_i & cells_q))
      |=> (err_reprog_o && $stable(cells_q)));
  // R8: no burning outside calibration mode
  a_r8_no_burn_outside: assert property (@(posedge clk) disable iff (rst)
    !cal_i |=> $stable(cells_q));
endmodule

// File: rtl/otp_cal_prog.sv
module otp_cal_prog
  import otp_cal_pkg::*;
#(
  parameter int OW = OFS_W,
  parameter int TW = TC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              dc,
  input  logic [BYTE_W-1:0] db,
  input  logic              prog_strobe,
  output logic [OW-1:0]     ofs_o,
  output logic [TW-1:0]     tc_o,
  output logic              sealed_o,
  output logic              cal_active_o,
  output logic              err_multi_o,
  output logic              err_reprog_o
);
  localparam int CW = OW + TW + 1;

  logic          cal;
  logic [CW-1:0] chain, cells;

  otp_mode_ctrl u_mode (
    .clk      (clk),
    .rst      (rst),
    .cmd_wr   (wr_en && !dc),
    .cmd      (db),
    .sealed_i (cells[0]),
    .cal_o    (cal)
  );

  otp_shift_chain #(.W(CW)) u_chain (
    .clk      (clk),
    .rst      (rst),
    .shift_en (wr_en && dc && cal),
    .bit_i    (db[0]),
    .chain_o  (chain)
  );

  otp_cell_bank #(.W(CW)) u_cells (
    .clk          (clk),
    .rst          (rst),
    .cal_i        (cal),
    .strobe_i     (prog_strobe),
    .pattern_i    (chain),
    .cells_o      (cells),
    .err_multi_o  (err_multi_o),
    .err_reprog_o (err_reprog_o)
  );

  // layout: [CW-1 -: OW] offset, [TW:1] coefficient, [0] seal
  assign ofs_o        = cells[CW-1 -: OW];
  assign tc_o         = cells[TW:1];
  assign sealed_o     = cells[0];
  assign cal_active_o = cal;
endmodule

// File: tb/otp_cal_prog_test.sv
`timescale 1ns/1ps
module otp_cal_prog_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, dc = 1'b0, prog_strobe = 1'b0;
  logic [7:0] db = 8'h00;
  logic [4:0] ofs_o;
  logic [2:0] tc_o;
  logic       sealed_o, cal_active_o, err_multi_o, err_reprog_o;

  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  otp_cal_prog uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .dc(dc), .db(db),
    .prog_strobe(prog_strobe), .ofs_o(ofs_o), .tc_o(tc_o),
    .sealed_o(sealed_o), .cal_active_o(cal_active_o),
    .err_multi_o(err_multi_o), .err_reprog_o(err_reprog_o)
  );

  // op: 0 idle, 1 command, 2 data, 3 strobe
  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  byt;
    logic [11:0] exp; // {cal, ofs[4:0], tc[2:0], seal, err_multi, err_reprog}
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VT [NV] = '{
    '{2'd1, 8'h30, 12'b0_00000_000_000, 4'd2},  // R2 enter refused, no power-down
    '{2'd1, 8'h20, 12'b0_00000_000_000, 4'd2},  // R2 power-down
    '{2'd1, 8'h30, 12'b1_00000_000_000, 4'd2},  // R2 enter accepted
    '{2'd2, 8'h01, 12'b1_00000_000_000, 4'd3},  // R3 shift 1
    '{2'd2, 8'hFE, 12'b1_00000_000_000, 4'd3},  // R3 only db[0] counts
    '{2'd2, 8'h00, 12'b1_00000_000_000, 4'd3},
    '{2'd2, 8'h00, 12'b1_00000_000_000, 4'd3},  // chain now targets tc bit 2
    '{2'd3, 8'h00, 12'b1_00000_100_000, 4'd4},  // R4 burn tc bit 2
    '{2'd3, 8'h00, 12'b1_00000_100_001, 4'd6},  // R6 re-burn flagged
    '{2'd0, 8'h00, 12'b1_00000_100_000, 4'd6},  // R6 flag is one cycle
    '{2'd2, 8'h01, 12'b1_00000_100_000, 4'd3},  // chain = two ones
    '{2'd3, 8'h00, 12'b1_00000_100_010, 4'd7},  // R7 multi flagged, nothing burned
    '{2'd1, 8'h31, 12'b0_00000_100_000, 4'd2},  // R2 exit
    '{2'd3, 8'h00, 12'b0_00000_100_000, 4'd8}   // R8 strobe ignored outside mode
  };

  function automatic logic [11:0] obs();
    return {cal_active_o, ofs_o, tc_o, sealed_o, err_multi_o, err_reprog_o};
  endfunction

  task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic [1:0] op, input logic [7:0] b);
    @(negedge clk);
    wr_en = (op == 2'd1) || (op == 2'd2);
    dc = (op == 2'd2);
    db = b;
    prog_strobe = (op == 2'd3);
    @(negedge clk);
    wr_en = 1'b0; dc = 1'b0; prog_strobe = 1'b0; db = 8'h00;
  endtask

  task automatic load9(input logic [8:0] p);
    for (int i = 8; i >= 0; i--) do_op(2'd2, {7'd0, p[i]});
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    check("R1 reset state", obs(), 12'b0);

    for (int k = 0; k < NV; k++) begin
      do_op(VT[k].op, VT[k].byt);
      check($sformatf("R%0d vector %0d", VT[k].req, k), obs(), VT[k].exp);
    end

    // R11 any order: offset bit 0 then offset bit 4
    do_op(2'd1, 8'h30);
    load9(9'b000010000); do_op(2'd3, 8'h00);
    check("R11 offset bit0", obs(), 12'b1_00001_100_000);
    load9(9'b100000000); do_op(2'd3, 8'h00);
    check("R3 R11 offset bit4", obs(), 12'b1_10001_100_000);

    // R10: reset in mode keeps fuses, leaves mode and power-down, clears chain
    load9(9'b000000010);
    do_reset();
    check("R10 reset keeps fuses", obs(), 12'b0_10001_100_000);
    do_op(2'd1, 8'h30);
    check("R10 power-down cleared", obs(), 12'b0_10001_100_000);
    do_op(2'd1, 8'h20); do_op(2'd1, 8'h30);
    do_op(2'd3, 8'h00);
    check("R10 chain cleared", obs(), 12'b1_10001_100_000);

    // R8: data writes outside mode do not reach the chain
    do_op(2'd1, 8'h31);
    do_op(2'd2, 8'h01); do_op(2'd2, 8'h01);
    do_op(2'd1, 8'h30); do_op(2'd3, 8'h00);
    check("R8 data ignored outside", obs(), 12'b1_10001_100_000);

    // R3 overflow: ten writes, the first drops out
    do_op(2'd2, 8'h01);
    load9(9'b000000100); do_op(2'd3, 8'h00);
    check("R3 overflow", obs(), 12'b1_10001_110_000);

    // R9: seal, still programmable in mode, then lockout
    load9(9'b000000001); do_op(2'd3, 8'h00);
    check("R9 seal burned", obs(), 12'b1_10001_110_100);
    load9(9'b000000010); do_op(2'd3, 8'h00);
    check("R9 program after seal", obs(), 12'b1_10001_111_100);
    do_op(2'd1, 8'h31); do_op(2'd1, 8'h30);
    check("R9 lockout", obs(), 12'b0_10001_111_100);
    do_reset();
    do_op(2'd1, 8'h20); do_op(2'd1, 8'h30);
    check("R5 R9 lockout after reset", obs(), 12'b0_10001_111_100);

    finish_run();
  end
endmodule